// File: doc/BRIEF.md
# Register-Operand Execute Unit

This unit carries out the register-to-register instructions of a small 32-bit teaching processor: moves, adds, ANDs, fixed increments and decrements, bitwise complement, signed-amount shifts, and the two system codes that either stop the machine or do nothing. Each issued instruction is presented as a 4-bit opcode, three 4-bit operand fields, an 8-bit immediate and the current contents of the two named registers. The unit returns a registered write-back triple (enable, register index, value) for the register file, plus a sticky halted flag.

The register file, instruction fetch and memory access stay outside. An instruction is issued by raising `exec_en` for one cycle. Its write-back is visible on the outputs from the next rising edge. With eight registers, a register index is the low three bits of the 4-bit field that carries it.

Top module: `sm_exec_unit`

## Requirements
- R1: After reset, `wb_en` is 0 and `halted` is 0.
- R2: With opcode 0x6, `fld_a` holds a sub-code, `fld_b` holds s and `fld_c` holds d. Sub-code 0 writes r[s] to d, sub-code 1 writes r[d]+r[s], and sub-code 2 writes r[d] AND r[s].
- R3: Opcode 0x6 with sub-code 3 writes r[d]+1, and with sub-code 4 writes r[d]+4. Sums wrap modulo 2^32.
- R4: Opcode 0x6 with sub-code 5 writes r[d]-1, and with sub-code 6 writes r[d]-4. Differences wrap modulo 2^32.
- R5: Opcode 0x6 with sub-code 7 writes the bitwise complement of r[d].
- R6: Opcode 0x7 takes d from `fld_a` and reads `imm` as a two's-complement shift amount. A positive amount writes r[d] shifted left by that amount, and an amount of 0 writes r[d] unchanged.
- R7: Opcode 0x7 with a negative amount writes r[d] shifted right arithmetically (sign bit copied in) by the magnitude of the amount.
- R8: A shift magnitude of 32 or more gives 0 for a left shift and 32 copies of the sign bit for a right shift.
- R9: Opcode 0xF with `imm` = 0x00 sets `halted` one cycle after issue and makes no register write.
- R10: Opcode 0xF with `imm` = 0xFF, or with any other `imm` value except 0x00, makes no register write and leaves `halted` unchanged.
- R11: Once set, `halted` stays 1 until reset, and no instruction issued while it is 1 produces a write.
- R12: Opcode 0x6 sub-codes 8 to 15, opcodes other than 0x6, 0x7 and 0xF, and cycles with `exec_en` low produce no write.
- R13: The write-back for an instruction issued at one rising edge appears on `wb_en`, `wb_idx` and `wb_data` after that edge, and the next edge replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Instruction issued this cycle |
| opcode | input | 4 | Major opcode |
| fld_a | input | 4 | Second instruction nibble |
| fld_b | input | 4 | Third instruction nibble |
| fld_c | input | 4 | Fourth instruction nibble |
| imm | input | 8 | Low instruction byte |
| rs_val | input | 32 | Current value of register s |
| rd_val | input | 32 | Current value of register d |
| wb_en | output | 1 | Register write enable |
| wb_idx | output | 3 | Register index to write |
| wb_data | output | 32 | Value to write |
| halted | output | 1 | Machine halted flag |

## Verification
Every result is due exactly one rising edge after issue. This applies to `wb_en`, `wb_idx`, `wb_data` and also `halted`. The bench drives each instruction at a falling edge and samples all four outputs at the following falling edge, which lies after the single register stage. The bench then compares them with values its own model computes for that instruction. Because every instruction is checked in the half-cycle window before the next one is driven, back-to-back random instructions still line up with their own results, and the check after a halt or an unused code sees directly that no write appeared.

// File: rtl/sm_exec_pkg.sv
package sm_exec_pkg;
  localparam logic [3:0] OPC_REGOP = 4'h6;
  localparam logic [3:0] OPC_SHIFT = 4'h7;
  localparam logic [3:0] OPC_SYS   = 4'hF;

  localparam logic [7:0] SYS_STOP  = 8'h00;
  localparam logic [7:0] SYS_IDLE  = 8'hFF;

  typedef enum logic [3:0] {
    SUB_MOV  = 4'd0,
    SUB_ADD  = 4'd1,
    SUB_AND  = 4'd2,
    SUB_INC1 = 4'd3,
    SUB_INC4 = 4'd4,
    SUB_DEC1 = 4'd5,
    SUB_DEC4 = 4'd6,
    SUB_NOT  = 4'd7
  } regop_sub_e;
endpackage

// File: rtl/sm_regop_unit.sv
module sm_regop_unit
  import sm_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        sub,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] dst_val,
  output logic [DATA_W-1:0] result,
  output logic              known
);
  localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] FOUR = DATA_W'(4);

  always_comb begin
    known  = 1'b1;
    result = '0;
    case (sub)
      SUB_MOV:  result = src_val;
      SUB_ADD:  result = dst_val + src_val;
      SUB_AND:  result = dst_val & src_val;
      SUB_INC1: result = dst_val + ONE;
      SUB_INC4: result = dst_val + FOUR;
      SUB_DEC1: result = dst_val - ONE;
      SUB_DEC4: result = dst_val - FOUR;
      SUB_NOT:  result = ~dst_val;
      default:  known  = 1'b0;
    endcase
  end
endmodule

// File: rtl/sm_shift_unit.sv
module sm_shift_unit #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [AMT_W-1:0]  amount,
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] result
);
  logic             go_right;
  logic [AMT_W-1:0] mag;

  always_comb begin
    go_right = amount[AMT_W-1];
    mag      = go_right ? (~amount + AMT_W'(1)) : amount;
    if (go_right) begin
      if (int'(mag) >= DATA_W) result = {DATA_W{value[DATA_W-1]}};
      else                     result = DATA_W'($signed(value) >>> mag);
    end else begin
      if (int'(mag) >= DATA_W) result = '0;
      else                     result = value << mag;
    end
  end
endmodule

// File: rtl/sm_halt_ctl.sv
module sm_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  output logic halted_q
);
  logic halted_d;

  always_comb halted_d = halted_q | stop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halted_q <= 1'b0;
    else        halted_q <= halted_d;
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q); // R11
endmodule

// File: rtl/sm_exec_unit.sv
module sm_exec_unit
  import sm_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [3:0]        opcode,
  input  logic [3:0]        fld_a,
  input  logic [3:0]        fld_b,
  input  logic [3:0]        fld_c,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rd_val,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              halted
);
  logic [DATA_W-1:0] reg_res, shf_res, data_d, data_q;
  logic              reg_known, we_d, we_q, stop_d, issue;
  logic [IDX_W-1:0]  idx_d, idx_q;

  sm_regop_unit #(.DATA_W(DATA_W)) u_regop (
    .sub(fld_a), .src_val(rs_val), .dst_val(rd_val),
    .result(reg_res), .known(reg_known)
  );

  sm_shift_unit #(.DATA_W(DATA_W), .AMT_W(IMM_W)) u_shift (
    .amount(imm), .value(rd_val), .result(shf_res)
  );

  assign issue = exec_en & ~halted;

  sm_halt_ctl u_halt (
    .clk(clk), .rst_n(rst_n), .stop_req(issue & stop_d), .halted_q(halted)
  );

  always_comb begin
    we_d   = 1'b0;
    stop_d = 1'b0;
    idx_d  = fld_c[IDX_W-1:0];
    data_d = reg_res;
    case (opcode)
      OPC_REGOP: we_d = reg_known;
      OPC_SHIFT: begin
        we_d   = 1'b1;
        idx_d  = fld_a[IDX_W-1:0];
        data_d = shf_res;
      end
      OPC_SYS:   stop_d = (imm == SYS_STOP);
      default:   we_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      we_q <= issue & we_d;
      if (issue & we_d) begin
        idx_q  <= idx_d;
        data_q <= data_d;
      end
    end
  end

  assign wb_en   = we_q;
  assign wb_idx  = idx_q;
  assign wb_data = data_q;

  AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !wb_en); // R11
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> !wb_en); // R12
  AST_UNUSED_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opcode == OPC_REGOP && fld_a[3]) |=> !wb_en); // R12
  AST_STOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opcode == OPC_SYS && imm == SYS_STOP) |=> (halted && !wb_en)); // R9
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opcode == OPC_SYS && imm == SYS_IDLE && !halted) |=> (!halted && !wb_en)); // R10
  AST_INC4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opcode == OPC_REGOP && fld_a == 4'd4)
      |=> (wb_en && wb_data == $past(rd_val) + DATA_W'(4))); // R3
endmodule

// File: tb/sm_exec_unit_tb.sv
module sm_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_en;
  logic [3:0]  opcode, fld_a, fld_b, fld_c;
  logic [7:0]  imm;
  logic [31:0] rs_val, rd_val;
  logic        wb_en, halted;
  logic [2:0]  wb_idx;
  logic [31:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit model_halted = 1'b0;

  always #10 clk = ~clk;

  sm_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
    .fld_a(fld_a), .fld_b(fld_b), .fld_c(fld_c), .imm(imm),
    .rs_val(rs_val), .rd_val(rd_val), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .halted(halted)
  );

  function automatic logic [31:0] ref_shift(logic [31:0] v, logic [7:0] a);
    int sa = int'($signed(a));
    if (sa >= 0) return (sa >= 32) ? 32'h0 : (v << sa);
    sa = -sa;
    if (sa >= 32) return {32{v[31]}};
    return 32'($signed(v) >>> sa);
  endfunction

  function automatic string req_of(logic en, logic [3:0] op, logic [3:0] a, logic [7:0] i);
    if (!en) return "R12";
    if (op == 4'h6) begin
      if (a <= 4'd2) return "R2";
      if (a <= 4'd4) return "R3";
      if (a <= 4'd6) return "R4";
      if (a == 4'd7) return "R5";
      return "R12";
    end
    if (op == 4'h7) begin
      if ($signed(i) >= 32 || $signed(i) <= -32) return "R8";
      if (i[7]) return "R7";
      return "R6";
    end
    if (op == 4'hF) return (i == 8'h00) ? "R9" : "R10";
    return "R12";
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(logic en, logic [3:0] op, logic [3:0] a, logic [3:0] b,
                     logic [3:0] c, logic [7:0] i, logic [31:0] rs, logic [31:0] rd);
    logic        e_we;
    logic [2:0]  e_idx;
    logic [31:0] e_data;
    string       req;
    e_we = 1'b0; e_idx = 3'd0; e_data = 32'h0;
    req = model_halted ? "R11" : req_of(en, op, a, i);
    if (en && !model_halted) begin
      if (op == 4'h6) begin
        e_idx = c[2:0];
        e_we  = (a < 4'd8);
        case (a)
          4'd0: e_data = rs;
          4'd1: e_data = rd + rs;
          4'd2: e_data = rd & rs;
          4'd3: e_data = rd + 32'd1;
          4'd4: e_data = rd + 32'd4;
          4'd5: e_data = rd - 32'd1;
          4'd6: e_data = rd - 32'd4;
          4'd7: e_data = ~rd;
          default: e_data = 32'h0;
        endcase
      end else if (op == 4'h7) begin
        e_we = 1'b1; e_idx = a[2:0]; e_data = ref_shift(rd, i);
      end else if (op == 4'hF && i == 8'h00) begin
        model_halted = 1'b1;
      end
    end
    @(negedge clk);
    exec_en = en; opcode = op; fld_a = a; fld_b = b; fld_c = c;
    imm = i; rs_val = rs; rd_val = rd;
    @(negedge clk);
    exec_en = 1'b0;
    // R13: results sampled one edge after issue
    check(req, "wb_en", 32'(wb_en), 32'(e_we));
    check(req, "halted", 32'(halted), 32'(model_halted));
    if (e_we) begin
      check(req, "wb_idx", 32'(wb_idx), 32'(e_idx));
      check(req, "wb_data", wb_data, e_data);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; exec_en = 1'b0; opcode = 4'h0; fld_a = 4'h0; fld_b = 4'h0;
    fld_c = 4'h0; imm = 8'h0; rs_val = 32'h0; rd_val = 32'h0;
    repeat (3) @(negedge clk);
    check("R1", "wb_en", 32'(wb_en), 32'h0);
    check("R1", "halted", 32'(halted), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R3 R4 R5 directed
    run(1, 4'h6, 4'd0, 4'd1, 4'd2, 8'h12, 32'hDEADBEEF, 32'h1);
    run(1, 4'h6, 4'd1, 4'd1, 4'd3, 8'h13, 32'hFFFFFFFF, 32'h2);
    run(1, 4'h6, 4'd2, 4'd1, 4'd4, 8'h14, 32'hF0F0F0F0, 32'h3C3C3C3C);
    run(1, 4'h6, 4'd3, 4'd0, 4'd5, 8'h05, 32'h0, 32'hFFFFFFFF);
    run(1, 4'h6, 4'd4, 4'd0, 4'd6, 8'h06, 32'h0, 32'hFFFFFFFE);
    run(1, 4'h6, 4'd5, 4'd0, 4'd7, 8'h07, 32'h0, 32'h0);
    run(1, 4'h6, 4'd6, 4'd0, 4'd9, 8'h09, 32'h0, 32'h2);
    run(1, 4'h6, 4'd7, 4'd0, 4'd1, 8'h01, 32'h0, 32'h00FF00FF);
    // R6 R7 R8 directed shifts
    run(1, 4'h7, 4'd2, 4'h0, 4'h0, 8'h00, 32'h0, 32'h12345678);
    run(1, 4'h7, 4'd3, 4'h0, 4'h4, 8'h04, 32'h0, 32'h80000001);
    run(1, 4'h7, 4'd4, 4'hF, 4'hC, 8'hFC, 32'h0, 32'h80000010);
    run(1, 4'h7, 4'd5, 4'hF, 4'hF, 8'hFF, 32'h0, 32'h7FFFFFFE);
    run(1, 4'h7, 4'd6, 4'h2, 4'h0, 8'h20, 32'h0, 32'hFFFFFFFF);
    run(1, 4'h7, 4'd7, 4'hE, 4'h0, 8'hE0, 32'h0, 32'h80000000);
    run(1, 4'h7, 4'd0, 4'h8, 4'h0, 8'h80, 32'h0, 32'h40000000);
    run(1, 4'h7, 4'd1, 4'h7, 4'hF, 8'h7F, 32'h0, 32'hFFFFFFFF);
    // R10 R12 directed
    run(1, 4'hF, 4'd0, 4'hF, 4'hF, 8'hFF, 32'h1, 32'h2);
    run(1, 4'hF, 4'd0, 4'h1, 4'h2, 8'h12, 32'h1, 32'h2);
    run(1, 4'h6, 4'd8, 4'd1, 4'd2, 8'h12, 32'h1, 32'h2);
    run(1, 4'h6, 4'd15, 4'd1, 4'd2, 8'h12, 32'h1, 32'h2);
    run(1, 4'h0, 4'd1, 4'd1, 4'd2, 8'h12, 32'h1, 32'h2);
    run(0, 4'h6, 4'd1, 4'd1, 4'd2, 8'h12, 32'h1, 32'h2);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] op, a, b, c;
      logic [7:0] i;
      int pick = $urandom_range(0, 9);
      op = (pick < 4) ? 4'h6 : (pick < 7) ? 4'h7 : (pick < 8) ? 4'hF : 4'($urandom);
      a = 4'($urandom); b = 4'($urandom); c = 4'($urandom);
      i = {b, c};
      if (op == 4'hF && i == 8'h00) begin c = 4'h1; i = 8'h01; end
      run(($urandom_range(0, 7) != 0), op, a, b, c, i, $urandom, $urandom);
    end
    // R9 halt, then R11 no writes
    run(1, 4'hF, 4'd0, 4'h0, 4'h0, 8'h00, 32'h5, 32'h6);
    run(1, 4'h6, 4'd1, 4'd1, 4'd2, 8'h12, 32'h5, 32'h6);
    run(1, 4'h7, 4'd1, 4'h0, 4'h1, 8'h01, 32'h5, 32'h6);
    run(1, 4'hF, 4'd0, 4'hF, 4'hF, 8'hFF, 32'h5, 32'h6);
    run(0, 4'h0, 4'd0, 4'h0, 4'h0, 8'h00, 32'h0, 32'h0);
    // R1 reset clears halt
    rst_n = 1'b0;
    @(negedge clk);
    model_halted = 1'b0;
    check("R1", "halted after reset", 32'(halted), 32'h0);
    check("R1", "wb_en after reset", 32'(wb_en), 32'h0);
    rst_n = 1'b1;
    run(1, 4'h6, 4'd3, 4'd0, 4'd2, 8'h02, 32'h0, 32'h41);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule